// File: doc/BRIEF.md
# Peer Setup Message Sequencer

This block follows the connection handshake of one client that joins a group of peers sharing a memory region. An upstream transport delivers 64-bit signed setup messages, one per `msg_valid` cycle. Each message carries a flag that says whether a descriptor handle came with it. The block walks through a fixed order of phases:

- a protocol version check;
- the client's own ID;
- the shared-memory grant;
- per-peer vector handles;
- the client's own receive vectors.

After that it handles connect and disconnect notifications for as long as the connection lasts. The handles themselves are stored elsewhere. This block only counts and classifies them.

A small associative table records the connected peers and how many vectors each one has connected. Any agent can query it by peer ID. Any message that breaks the handshake closes the connection: the block gives a one-cycle close pulse, then holds a sticky closed state and ignores all further messages until reset. The client's own ID, the grant flag, a setup-complete flag and the count of connected receive vectors are offered as outputs.

Top module: `psq_setup_sequencer`

## Requirements
- R1: The first message must be the value 0. Any other value closes the connection. Closing raises `close_pulse` for exactly one cycle and `link_closed` until reset, and every later message is ignored.
- R2: The second message is the client's own ID and must lie in 0..65535. A value outside that range closes the connection. A valid ID appears on `client_id`, with `id_known` set, and stays stable afterwards.
- R3: The third message must be the value -1 (all 64 bits set) with its handle flag set. This sets `shm_ready`. Any other value, or -1 without a handle, closes the connection.
- R4: While peer handles are arriving, a peer ID that comes with a handle adds one vector to that peer's table entry. The count saturates at MAX_VECS (default 4), so extra handles are discarded.
- R5: A message equal to the own ID and carrying a handle adds one own receive vector, saturating at MAX_VECS. The first such message sets `setup_done` and ends the peer-handle phase.
- R6: After setup completes, a peer ID with a handle connects that peer's next vector. A new peer starts at 1.
- R7: After setup completes, a peer ID without a handle clears that peer's entry. A disconnect for an unknown peer changes nothing and does not close the connection.
- R8: After the grant, the connection closes on any of these: a value outside 0..65535; a handle-less message before `setup_done`; the own ID without a handle.
- R9: With the default policy (FULL_IS_ERROR=1), a connect for a new peer when all NUM_PEERS entries (default 4) are in use closes the connection and allocates nothing.
- R10: `qry_hit`/`qry_vecs` follow `qry_id` combinationally from the table as it stood after the last clock edge. A message's effect on the table becomes visible only after the edge that accepts it.
- R11: After reset, `id_known`, `shm_ready`, `setup_done`, `link_closed`, `close_pulse` and `qry_hit` are 0, and `own_vecs` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A message is present this cycle |
| msg_value | input | 64 | Signed message value |
| msg_handle | input | 1 | A descriptor handle accompanies the message |
| qry_id | input | 16 | Peer ID to look up |
| client_id | output | 16 | The client's own ID |
| id_known | output | 1 | `client_id` is valid |
| shm_ready | output | 1 | Shared-memory grant received |
| setup_done | output | 1 | First own receive vector received |
| own_vecs | output | CNT_W (3) | Connected own receive vectors |
| link_closed | output | 1 | Connection closed after a protocol error |
| close_pulse | output | 1 | One-cycle strobe on closing |
| qry_hit | output | 1 | `qry_id` is a connected peer |
| qry_vecs | output | CNT_W (3) | Vector count of the queried peer |

## Verification
The table lookup and a table update can land in the same cycle. This happens when `qry_id` names a peer whose connect or disconnect message is being presented. The bench holds `qry_id` on a connected peer and drives a disconnect for that same peer. It samples the lookup shortly after driving, before the clock edge, and expects the old count. After the edge it expects a miss. A second pair of functions that can overlap is a new-peer connect meeting a full table; that case is judged by the close pulse and by the absence of the new entry.

// File: rtl/psq_pkg.sv
package psq_pkg;
   localparam int MSG_W = 64;
   localparam int ID_W  = 16;

   typedef enum logic [2:0] {
      PH_VER   = 3'd0,
      PH_ID    = 3'd1,
      PH_SHM   = 3'd2,
      PH_PEERS = 3'd3,
      PH_RUN   = 3'd4,
      PH_DEAD  = 3'd5
   } phase_e;

   typedef struct packed {
      logic in_range;
      logic is_zero;
      logic is_grant;
   } msg_class_t;
endpackage

// File: rtl/psq_classify.sv
module psq_classify
   import psq_pkg::*;
(
   input  logic [MSG_W-1:0] value,
   output msg_class_t       cls,
   output logic [ID_W-1:0]  id
);
   always_comb begin
      cls.in_range = (value[MSG_W-1:ID_W] == '0);
      cls.is_zero  = (value == '0);
      cls.is_grant = &value;
      id           = value[ID_W-1:0];
   end
endmodule

// File: rtl/psq_peer_table.sv
module psq_peer_table
   import psq_pkg::*;
#(
   parameter int NUM_PEERS     = 4,
   parameter int MAX_VECS      = 4,
   parameter bit FULL_IS_ERROR = 1'b1,
   parameter int CNT_W         = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_valid,
   input  logic             upd_connect,
   input  logic [ID_W-1:0]  upd_id,
   output logic             upd_reject,
   input  logic [ID_W-1:0]  qry_id,
   output logic             qry_hit,
   output logic [CNT_W-1:0] qry_vecs
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_VECS);

   logic [NUM_PEERS-1:0]            vld;
   logic [NUM_PEERS-1:0]            hit_upd;
   logic [NUM_PEERS-1:0]            hit_qry;
   logic [NUM_PEERS-1:0]            first_free;
   logic [NUM_PEERS-1:0][CNT_W-1:0] masked_cnt;
   logic                            any_hit;
   logic                            any_free;
   logic                            need_new;

   always_comb begin
      first_free = '0;
      for (int i = 0; i < NUM_PEERS; i++) begin
         if (!vld[i] && (first_free == '0)) first_free[i] = 1'b1;
      end
   end

   assign any_hit  = |hit_upd;
   assign any_free = ~&vld;
   assign need_new = upd_valid && upd_connect && !any_hit;

   generate
      if (FULL_IS_ERROR) begin : g_full_err
         assign upd_reject = need_new && !any_free;
      end else begin : g_full_drop
         assign upd_reject = 1'b0;
      end
   endgenerate

   for (genvar i = 0; i < NUM_PEERS; i++) begin : g_ent
      logic             vld_q;
      logic [ID_W-1:0]  id_q;
      logic [CNT_W-1:0] cnt_q;

      assign vld[i]        = vld_q;
      assign hit_upd[i]    = vld_q && (id_q == upd_id);
      assign hit_qry[i]    = vld_q && (id_q == qry_id);
      assign masked_cnt[i] = hit_qry[i] ? cnt_q : '0;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            id_q  <= '0;
            cnt_q <= '0;
         end else if (upd_valid) begin
            if (upd_connect) begin
               if (hit_upd[i]) begin
                  if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
               end else if (need_new && first_free[i]) begin
                  vld_q <= 1'b1;
                  id_q  <= upd_id;
                  cnt_q <= CNT_W'(1);
               end
            end else if (hit_upd[i]) begin
               vld_q <= 1'b0;
               cnt_q <= '0;
            end
         end
      end

      assert_entry_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
         vld_q |-> ((cnt_q != '0) && (cnt_q <= CNT_MAX)));

      assert_entry_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (upd_valid && !upd_connect && hit_upd[i]) |=> !vld_q);
   end

   always_comb begin
      qry_vecs = '0;
      for (int i = 0; i < NUM_PEERS; i++) qry_vecs = qry_vecs | masked_cnt[i];
   end
   assign qry_hit = |hit_qry;

   assert_query_unique_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_qry));
endmodule

// File: rtl/psq_setup_fsm.sv
module psq_setup_fsm
   import psq_pkg::*;
#(
   parameter int MAX_VECS = 4,
   parameter int CNT_W    = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msg_valid,
   input  logic             msg_handle,
   input  msg_class_t       cls,
   input  logic [ID_W-1:0]  id,
   input  logic             tbl_reject,
   output logic             tbl_upd_valid,
   output logic             tbl_upd_connect,
   output logic [ID_W-1:0]  client_id,
   output logic             id_known,
   output logic             shm_ready,
   output logic             setup_done,
   output logic [CNT_W-1:0] own_vecs,
   output logic             link_closed,
   output logic             close_pulse
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_VECS);

   phase_e phase_q, phase_d;
   logic   fault_base, fault, is_own, own_inc, tbl_req, live;

   assign live   = msg_valid && (phase_q != PH_DEAD);
   assign is_own = id_known && cls.in_range && (id == client_id);

   always_comb begin
      fault_base      = 1'b0;
      phase_d         = phase_q;
      own_inc         = 1'b0;
      tbl_req         = 1'b0;
      tbl_upd_connect = 1'b1;
      unique case (phase_q)
         PH_VER: begin
            fault_base = !cls.is_zero;
            phase_d    = PH_ID;
         end
         PH_ID: begin
            fault_base = !cls.in_range;
            phase_d    = PH_SHM;
         end
         PH_SHM: begin
            fault_base = !(cls.is_grant && msg_handle);
            phase_d    = PH_PEERS;
         end
         PH_PEERS: begin
            fault_base = !cls.in_range || !msg_handle;
            if (is_own) begin
               own_inc = 1'b1;
               phase_d = PH_RUN;
            end else begin
               tbl_req = 1'b1;
            end
         end
         PH_RUN: begin
            fault_base = !cls.in_range || (is_own && !msg_handle);
            if (is_own) begin
               own_inc = 1'b1;
            end else begin
               tbl_req         = 1'b1;
               tbl_upd_connect = msg_handle;
            end
         end
         default: phase_d = PH_DEAD;
      endcase
   end

   assign tbl_upd_valid = live && tbl_req && !fault_base;
   assign fault         = fault_base || tbl_reject;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= PH_VER;
         client_id   <= '0;
         id_known    <= 1'b0;
         shm_ready   <= 1'b0;
         setup_done  <= 1'b0;
         own_vecs    <= '0;
         link_closed <= 1'b0;
         close_pulse <= 1'b0;
      end else begin
         close_pulse <= 1'b0;
         if (live) begin
            if (fault) begin
               phase_q     <= PH_DEAD;
               link_closed <= 1'b1;
               close_pulse <= 1'b1;
            end else begin
               phase_q <= phase_d;
               if (phase_q == PH_ID) begin
                  client_id <= id;
                  id_known  <= 1'b1;
               end
               if (phase_q == PH_SHM) shm_ready <= 1'b1;
               if (own_inc) begin
                  setup_done <= 1'b1;
                  if (own_vecs != CNT_MAX) own_vecs <= own_vecs + 1'b1;
               end
            end
         end
      end
   end

   assert_closed_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      link_closed |=> link_closed);

   assert_pulse_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      close_pulse |=> !close_pulse);

   assert_id_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      id_known |=> (id_known && $stable(client_id)));

   assert_done_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      setup_done |-> shm_ready);

   assert_own_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
      own_vecs <= CNT_MAX);

   assert_full_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (live && tbl_reject) |=> link_closed);
endmodule

// File: rtl/psq_setup_sequencer.sv
module psq_setup_sequencer
   import psq_pkg::*;
#(
   parameter int NUM_PEERS     = 4,
   parameter int MAX_VECS      = 4,
   parameter bit FULL_IS_ERROR = 1'b1,
   localparam int CNT_W        = $clog2(MAX_VECS + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msg_valid,
   input  logic [63:0]      msg_value,
   input  logic             msg_handle,
   input  logic [15:0]      qry_id,
   output logic [15:0]      client_id,
   output logic             id_known,
   output logic             shm_ready,
   output logic             setup_done,
   output logic [CNT_W-1:0] own_vecs,
   output logic             link_closed,
   output logic             close_pulse,
   output logic             qry_hit,
   output logic [CNT_W-1:0] qry_vecs
);
   generate
      if (NUM_PEERS < 1 || NUM_PEERS > 256) begin : g_bad_peers
         $error("NUM_PEERS must lie in 1..256");
      end
      if (MAX_VECS < 1 || MAX_VECS > 1024) begin : g_bad_vecs
         $error("MAX_VECS must lie in 1..1024");
      end
   endgenerate

   msg_class_t      cls;
   logic [ID_W-1:0] msg_id;
   logic            tbl_upd_valid, tbl_upd_connect, tbl_reject;

   psq_classify u_classify (
      .value (msg_value),
      .cls   (cls),
      .id    (msg_id)
   );

   psq_setup_fsm #(
      .MAX_VECS (MAX_VECS),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .msg_valid       (msg_valid),
      .msg_handle      (msg_handle),
      .cls             (cls),
      .id              (msg_id),
      .tbl_reject      (tbl_reject),
      .tbl_upd_valid   (tbl_upd_valid),
      .tbl_upd_connect (tbl_upd_connect),
      .client_id       (client_id),
      .id_known        (id_known),
      .shm_ready       (shm_ready),
      .setup_done      (setup_done),
      .own_vecs        (own_vecs),
      .link_closed     (link_closed),
      .close_pulse     (close_pulse)
   );

   psq_peer_table #(
      .NUM_PEERS     (NUM_PEERS),
      .MAX_VECS      (MAX_VECS),
      .FULL_IS_ERROR (FULL_IS_ERROR),
      .CNT_W         (CNT_W)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd_valid   (tbl_upd_valid),
      .upd_connect (tbl_upd_connect),
      .upd_id      (msg_id),
      .upd_reject  (tbl_reject),
      .qry_id      (qry_id),
      .qry_hit     (qry_hit),
      .qry_vecs    (qry_vecs)
   );
endmodule

// File: tb/psq_setup_sequencer_tb.sv
`timescale 1ns/1ps
module psq_setup_sequencer_tb;
   localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_valid = 1'b0;
   logic [63:0] msg_value = '0;
   logic        msg_handle = 1'b0;
   logic [15:0] qry_id = '0;
   logic [15:0] client_id;
   logic        id_known, shm_ready, setup_done, link_closed, close_pulse, qry_hit;
   logic [2:0]  own_vecs, qry_vecs;
   int          n_run = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   psq_setup_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_value(msg_value),
      .msg_handle(msg_handle), .qry_id(qry_id), .client_id(client_id),
      .id_known(id_known), .shm_ready(shm_ready), .setup_done(setup_done),
      .own_vecs(own_vecs), .link_closed(link_closed), .close_pulse(close_pulse),
      .qry_hit(qry_hit), .qry_vecs(qry_vecs)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; msg_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(input logic [63:0] v, input logic h);
      @(negedge clk);
      msg_valid = 1'b1; msg_value = v; msg_handle = h;
      @(negedge clk);
      msg_valid = 1'b0;
   endtask

   task automatic lookup(input string req, input logic [15:0] pid,
                         input logic hit, input logic [2:0] cnt);
      qry_id = pid;
      #0.5;
      check(req, {63'd0, qry_hit}, {63'd0, hit});
      check(req, {61'd0, qry_vecs}, {61'd0, cnt});
   endtask

   task automatic prefix(input logic [15:0] own);
      do_reset();
      send(64'd0, 1'b0);
      send({48'd0, own}, 1'b0);
      send(NEG1, 1'b1);
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      check("R11 id_known", id_known, 0);
      check("R11 shm_ready", shm_ready, 0);
      check("R11 setup_done", setup_done, 0);
      check("R11 link_closed", link_closed, 0);
      check("R11 close_pulse", close_pulse, 0);
      check("R11 own_vecs", own_vecs, 0);
      lookup("R11 lookup", 16'd0, 1'b0, 3'd0);
   endtask

   task automatic t_bad_version();
      do_reset();
      send(64'd5, 1'b0);
      check("R1 closed", link_closed, 1);
      check("R1 pulse", close_pulse, 1);
      @(negedge clk);
      check("R1 pulse single", close_pulse, 0);
      send(64'd0, 1'b0);
      send(64'd3, 1'b0);
      check("R1 ignored after close", id_known, 0);
      check("R1 still closed", link_closed, 1);
   endtask

   task automatic t_bad_id();
      do_reset();
      send(64'd0, 1'b0);
      send(64'd65536, 1'b0);
      check("R2 id too large", link_closed, 1);
      check("R2 id not taken", id_known, 0);
      do_reset();
      send(64'd0, 1'b0);
      send(64'hFFFF_FFFF_FFFF_FFFB, 1'b0);
      check("R2 negative id", link_closed, 1);
      do_reset();
      send(64'd0, 1'b0);
      send(64'd65535, 1'b0);
      check("R2 max id ok", link_closed, 0);
      check("R2 max id value", client_id, 16'hFFFF);
   endtask

   task automatic t_bad_grant();
      do_reset();
      send(64'd0, 1'b0);
      send(64'd1, 1'b0);
      send(NEG1, 1'b0);
      check("R3 grant without handle", link_closed, 1);
      check("R3 shm not ready", shm_ready, 0);
      do_reset();
      send(64'd0, 1'b0);
      send(64'd1, 1'b0);
      send(64'hFFFF_FFFF_FFFF_FFFE, 1'b1);
      check("R3 wrong grant value", link_closed, 1);
   endtask

   task automatic t_normal();
      prefix(16'd5);
      check("R2 client_id", client_id, 5);
      check("R2 id_known", id_known, 1);
      check("R3 shm_ready", shm_ready, 1);
      check("R5 not done yet", setup_done, 0);
      repeat (3) send(64'd2, 1'b1);
      repeat (6) send(64'd7, 1'b1);
      lookup("R4 peer 2 count", 16'd2, 1'b1, 3'd3);
      lookup("R4 peer 7 saturated", 16'd7, 1'b1, 3'd4);
      send(64'd5, 1'b1);
      check("R5 setup_done", setup_done, 1);
      check("R5 own_vecs 1", own_vecs, 1);
      repeat (5) send(64'd5, 1'b1);
      check("R5 own_vecs saturated", own_vecs, 4);
      send(64'd9, 1'b1);
      lookup("R6 new peer", 16'd9, 1'b1, 3'd1);
      send(64'd2, 1'b1);
      lookup("R6 next vector", 16'd2, 1'b1, 3'd4);
      send(64'd2, 1'b0);
      lookup("R7 disconnected", 16'd2, 1'b0, 3'd0);
      lookup("R7 other peer kept", 16'd7, 1'b1, 3'd4);
      send(64'd11, 1'b0);
      check("R7 unknown disconnect no close", link_closed, 0);
      lookup("R7 unknown disconnect no effect", 16'd9, 1'b1, 3'd1);
      // R10: lookup and disconnect of the same peer in one cycle
      qry_id = 16'd7;
      @(negedge clk);
      msg_valid = 1'b1; msg_value = 64'd7; msg_handle = 1'b0;
      #1;
      check("R10 old value before edge", {61'd0, qry_vecs}, 64'd4);
      check("R10 hit before edge", qry_hit, 1);
      @(negedge clk);
      msg_valid = 1'b0;
      check("R10 miss after edge", qry_hit, 0);
      send(64'd5, 1'b0);
      check("R8 own id without handle", link_closed, 1);
   endtask

   task automatic t_setup_faults();
      prefix(16'd5);
      send(64'd2, 1'b0);
      check("R8 no handle in setup", link_closed, 1);
      prefix(16'd5);
      send(64'd5, 1'b1);
      send(NEG1, 1'b1);
      check("R8 out of range in run", link_closed, 1);
   endtask

   task automatic t_full();
      prefix(16'd0);
      for (int p = 1; p <= 4; p++) send(64'(p), 1'b1);
      lookup("R9 fourth peer held", 16'd4, 1'b1, 3'd1);
      check("R9 not closed at capacity", link_closed, 0);
      send(64'd6, 1'b1);
      check("R9 full table closes", link_closed, 1);
      check("R9 close pulse", close_pulse, 1);
      lookup("R9 no allocation", 16'd6, 1'b0, 3'd0);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_bad_version();
      t_bad_id();
      t_bad_grant();
      t_normal();
      t_setup_faults();
      t_full();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule